// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a small binary up-counter with a parallel preset. Every state bit is clocked by the same rising edge. Because of this, the count bits always change together, and no bit ever clocks a later bit. An active-low clear input sets the count to zero at once, without waiting for a clock edge.

A registered load loads a preset word. The load overrides counting. Counting itself needs two enables at the same time:

- The first enable is a parallel enable that is shared by all stages.
- The second is a chain enable. It also qualifies the terminal-count carry.

To build a wider synchronous counter, connect the carry of one stage to the chain enable of the next stage. All stages run from one clock, and no extra gates are needed between them.

The default width is four bits. The width is a parameter, and a second parameter selects how the increment is built.

Top module: `presettable_counter`

## Requirements
- R1: While `clr_n` is low, `count` is 0 within the same clock phase, whatever the levels of `clk`, `load_n`, `en_par` and `en_chain`.
- R2: With `clr_n` high and `load_n` low at a rising edge, `count` takes the value of `preset`, whatever the levels of both enables.
- R3: Every preset value from 0 to 2^WIDTH-1 loads exactly, including the two extremes, all zeros and all ones.
- R4: With `clr_n` and `load_n` high and both enables high at a rising edge, `count` increases by one.
- R5: With `load_n` high and either enable low at a rising edge, `count` keeps its value.
- R6: An increment from the all-ones value produces 0.
- R7: `carry` is a combinational output. It is high exactly when `en_chain` is high and `count` is all ones.
- R8: Suppose several stages share one clock, and each stage's `carry` drives the next stage's `en_chain`. The chain then forms one binary counter. With three 4-bit stages, it counts through 4095 and wraps to 0.
- R9: Changes on `load_n`, `preset` or the enables between rising edges leave `count` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous preset load, active low |
| preset | input | WIDTH | Value taken on a load |
| en_par | input | 1 | Parallel count enable |
| en_chain | input | 1 | Chain count enable; also qualifies `carry` |
| count | output | WIDTH | Current count |
| carry | output | 1 | Terminal-count carry for the next stage |

## Verification
The hardest condition to reach is the carry arriving at the top stage of a chain. That stage sees its chain enable only while every lower stage sits at all ones, which happens once every 256 clocks in a 3-stage chain. The stimulus loads zero into a 3-stage chain and holds both enables for a full 4096-clock period. On every clock it compares the combined value and the top carry against an integer model, through 4095 and the wrap to 0. On a single stage, the bench also applies random loads, enable patterns and mid-cycle clears. It also drives input pulses between edges, to show that only the edge samples the inputs.

// File: rtl/pcnt_pkg.sv
`timescale 1ns/1ps
package pcnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2
  } pcnt_mode_e;
endpackage

// File: rtl/pcnt_mode_sel.sv
`timescale 1ns/1ps
module pcnt_mode_sel
  import pcnt_pkg::*;
(
  input  logic       load_n,
  input  logic       en_par,
  input  logic       en_chain,
  output pcnt_mode_e mode
);
  // load wins over the enables; counting needs both enables
  always_comb begin
    if (!load_n)
      mode = MODE_LOAD;
    else if (en_par && en_chain)
      mode = MODE_COUNT;
    else
      mode = MODE_HOLD;
  end
endmodule

// File: rtl/pcnt_next_state.sv
`timescale 1ns/1ps
module pcnt_next_state
  import pcnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit LOOKAHEAD = 1'b1
) (
  input  pcnt_mode_e       mode,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] nxt
);
  logic [WIDTH-1:0] incr;

  generate
    if (LOOKAHEAD) begin : g_lookahead
      // bit i toggles when every lower bit is one
      logic [WIDTH-1:0] tog;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lsb
          assign tog[i] = 1'b1;
        end else begin : g_upper
          assign tog[i] = &cur[i-1:0];
        end
      end
      assign incr = cur ^ tog;
    end else begin : g_adder
      assign incr = cur + WIDTH'(1);
    end
  endgenerate

  always_comb begin
    unique case (mode)
      MODE_LOAD:  nxt = preset;
      MODE_COUNT: nxt = incr;
      default:    nxt = cur;
    endcase
  end
endmodule

// File: rtl/pcnt_carry_out.sv
`timescale 1ns/1ps
module pcnt_carry_out #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en_chain,
  output logic             carry
);
  logic at_top;
  assign at_top = &cur;
  assign carry  = en_chain & at_top;
endmodule

// File: rtl/presettable_counter.sv
`timescale 1ns/1ps
module presettable_counter
  import pcnt_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit LOOKAHEAD = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             en_par,
  input  logic             en_chain,
  output logic [WIDTH-1:0] count,
  output logic             carry
);
  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

  pcnt_mode_e       mode;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  pcnt_mode_sel u_mode (
    .load_n   (load_n),
    .en_par   (en_par),
    .en_chain (en_chain),
    .mode     (mode)
  );

  pcnt_next_state #(
    .WIDTH     (WIDTH),
    .LOOKAHEAD (LOOKAHEAD)
  ) u_next (
    .mode   (mode),
    .cur    (state_q),
    .preset (preset),
    .nxt    (state_d)
  );

  // all bits share one edge; clear acts without the clock
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)
      state_q <= '0;
    else
      state_q <= state_d;
  end

  assign count = state_q;

  pcnt_carry_out #(.WIDTH(WIDTH)) u_carry (
    .cur      (state_q),
    .en_chain (en_chain),
    .carry    (carry)
  );

  // R1: the clear gates the clock domain itself, so it is not disabled by itself
  a_r1_clear_zero: assert property (@(posedge clk)
    !clr_n |-> count == '0);

  a_r2_load_takes_preset: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(preset));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_chain) |=> count == WIDTH'($past(count) + 1'b1));

  a_r5_hold_value: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_par && en_chain)) |=> $stable(count));

  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_chain && count == TOP_VAL) |=> count == '0);

  a_r7_carry_only_at_top: assert property (@(posedge clk) disable iff (!clr_n)
    carry |-> (count == TOP_VAL && en_chain));

  a_r7_carry_present: assert property (@(posedge clk) disable iff (!clr_n)
    (en_chain && count == TOP_VAL) |-> carry);
endmodule

// File: tb/presettable_counter_bench.sv
`timescale 1ns/1ps
module pcnt_chain #(
  parameter int STAGES = 3,
  parameter int WIDTH  = 4
) (
  input  logic                    clk,
  input  logic                    clr_n,
  input  logic                    load_n,
  input  logic [STAGES*WIDTH-1:0] preset,
  input  logic                    en_par,
  input  logic                    en_first,
  output logic [STAGES*WIDTH-1:0] value,
  output logic                    carry_out
);
  logic [STAGES:0] link;
  assign link[0] = en_first;
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    presettable_counter #(.WIDTH(WIDTH)) u_stage (
      .clk      (clk),
      .clr_n    (clr_n),
      .load_n   (load_n),
      .preset   (preset[s*WIDTH +: WIDTH]),
      .en_par   (en_par),
      .en_chain (link[s]),
      .count    (value[s*WIDTH +: WIDTH]),
      .carry    (link[s+1])
    );
  end
  assign carry_out = link[STAGES];
endmodule

module presettable_counter_bench;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] preset = '0;
  logic       en_par = 1'b0;
  logic       en_chain = 1'b0;
  logic [3:0] count;
  logic       carry;

  logic        c_load_n = 1'b1;
  logic        c_en = 1'b0;
  logic [11:0] c_value;
  logic        c_carry;

  int n_checks = 0;
  int n_fail = 0;
  int ref_cnt = 0;
  int c_ref = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  presettable_counter #(.WIDTH(4)) u_presettable_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(preset),
    .en_par(en_par), .en_chain(en_chain), .count(count), .carry(carry)
  );

  pcnt_chain #(.STAGES(3), .WIDTH(4)) u_chain (
    .clk(clk), .clr_n(clr_n), .load_n(c_load_n), .preset(12'd0),
    .en_par(c_en), .en_first(c_en), .value(c_value), .carry_out(c_carry)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // starts just after a falling edge, ends at the next falling edge
  task automatic step(input logic ld, input logic [3:0] d, input logic ep,
                      input logic et, input bit glitch);
    string tag;
    load_n = ld; preset = d; en_par = ep; en_chain = et;
    #1;
    chk(carry === (et && ref_cnt == 15), "R7", int'(carry), int'(et && ref_cnt == 15));
    @(posedge clk);
    if (!ld) begin
      ref_cnt = d;
      tag = (d == 4'd0 || d == 4'd15) ? "R3" : "R2";
    end else if (ep && et) begin
      tag = (ref_cnt == 15) ? "R6" : "R4";
      ref_cnt = (ref_cnt + 1) % 16;
    end else begin
      tag = "R5";
    end
    if (glitch) begin
      #0.5;
      load_n = ~ld; preset = ~d; en_par = ~ep; en_chain = ~et;
      #0.7;
      load_n = ld; preset = d; en_par = ep; en_chain = et;
      tag = "R9";
    end
    @(negedge clk);
    chk(count === 4'(ref_cnt), tag, int'(count), ref_cnt);
  endtask

  // clear asserted mid-phase with the other inputs pushing against it
  task automatic pulse_clear();
    load_n = 1'b0; preset = 4'd9; en_par = 1'b1; en_chain = 1'b1;
    #1 clr_n = 1'b0;
    #0.5;
    ref_cnt = 0;
    chk(count === 4'd0, "R1", int'(count), 0);
    @(posedge clk);
    @(negedge clk);
    chk(count === 4'd0, "R1", int'(count), 0);
    @(posedge clk);
    #1 clr_n = 1'b1;
    load_n = 1'b1; en_par = 1'b0; en_chain = 1'b0;
    @(negedge clk);
    chk(count === 4'd0, "R1", int'(count), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1 clr_n = 1'b1;
    @(negedge clk);
    chk(count === 4'd0, "R1 reset", int'(count), 0);
    chk(c_value === 12'd0, "R1 chain reset", int'(c_value), 0);

    step(1'b0, 4'd15, 1'b0, 1'b0, 1'b0);   // R3 all ones, R2 enables low
    step(1'b1, 4'd0, 1'b1, 1'b0, 1'b0);    // R5 chain enable low, R7 carry low
    step(1'b1, 4'd0, 1'b1, 1'b1, 1'b0);    // R7 carry high, R6 wrap
    step(1'b0, 4'd0, 1'b1, 1'b1, 1'b0);    // R3 zero preset over enables
    step(1'b1, 4'd0, 1'b0, 1'b1, 1'b0);    // R5 parallel enable low
    for (int i = 0; i < 20; i++) step(1'b1, 4'd3, 1'b1, 1'b1, 1'b0);  // R4 runs
    step(1'b1, 4'd6, 1'b0, 1'b0, 1'b1);    // R9 mid-cycle pulses
    pulse_clear();

    for (int i = 0; i < 800; i++) begin
      if (i % 97 == 50) pulse_clear();
      else step(($urandom % 7) != 0, 4'($urandom), ($urandom % 4) != 0,
                ($urandom % 4) != 0, ($urandom % 10) == 0);
    end

    // R8: three chained stages through a full period
    c_load_n = 1'b0; c_en = 1'b0;
    @(posedge clk);
    c_ref = 0;
    @(negedge clk);
    c_load_n = 1'b1; c_en = 1'b1;
    for (int i = 0; i < 4100; i++) begin
      #1;
      chk(c_carry === (c_ref == 4095), "R8 carry", int'(c_carry), int'(c_ref == 4095));
      @(posedge clk);
      c_ref = (c_ref + 1) % 4096;
      @(negedge clk);
      chk(c_value === 12'(c_ref), "R8 value", int'(c_value), c_ref);
    end
    c_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(c_value === 12'(c_ref), "R8 hold", int'(c_value), c_ref);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule